// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a single memory access to an already translated page may proceed. A page walker supplies the combined protection attributes gathered along the walk: whether the final entry is present, whether any reserved bit was set, and the user, writable, no-execute and dirty attributes. The core supplies the access kind (read, write or instruction fetch), the current privilege level, the alignment-check flag, and the write-protect, supervisor-access-prevention, supervisor-execution-prevention and no-execute-enable controls.

The checker first selects one of three privilege-mode indices. This decides whether supervisor access prevention applies. It then applies the protection rules for that mode and reports a fault flag together with a page-fault error code. For a permitted access it also produces the read, write and execute rights that a TLB entry may cache. A separate input marks implicit supervisor accesses, such as descriptor-table reads, which use their own index rule. The output stage is registered by default (parameter `OUT_REG`), which gives one cycle of latency. With `OUT_REG = 0` the output stage is a plain wire.

Top module: `page_perm_check`

## Requirements
- R1: For an explicit access (`implicit_i` = 0), `mode_o` is USER (1) when `cpl_i` is all ones (level 3). Otherwise it is KERNEL-NO-SMAP (2) when `smap_en_i` is 0 or `ac_i` is 1, and KERNEL-SMAP (0) in every other case.
- R2: For an implicit supervisor access (`implicit_i` = 1), `mode_o` is KERNEL-NO-SMAP (2) when `smap_en_i` is 0, or when `cpl_i` is below 3 and `ac_i` is 1. Otherwise it is KERNEL-SMAP (0). It is never USER.
- R3: A fetch (`acc_i` = 2) to a present page with `pg_nx_i` = 1 is a protection fault in every mode.
- R4: In USER mode, any access to a page with `pg_user_i` = 0 faults. A write (`acc_i` = 1) to a page with `pg_write_i` = 0 also faults.
- R5: In KERNEL-SMAP mode, a read or write to a page with `pg_user_i` = 1 faults, while a fetch is exempt from this rule. The KERNEL-NO-SMAP rules of R6 apply on top.
- R6: In KERNEL-NO-SMAP mode, a fetch from a user page faults when `smep_en_i` = 1. A write to a page with `pg_write_i` = 0 faults only when `wp_en_i` = 1.
- R7: For a permitted access, `rd_ok_o` = 1. `ex_ok_o` = 1 only when `pg_nx_i` = 0 and not both `smep_en_i` and `pg_user_i` are set. `wr_ok_o` = 1 only when `pg_dirty_i` = 1 and either `pg_write_i` = 1 or the mode is not USER with `wp_en_i` = 0.
- R8: On a fault, error bit 0 is set for protection faults and reserved-bit faults, and bit 3 only for reserved-bit faults. A not-present fault (`present_i` = 0) leaves bits 0 and 3 clear. Bit 1 equals 1 for a write access.
- R9: On a fault, error bit 2 is set when the mode is USER. Error bit 4 is set when the access is a fetch and `nxe_en_i` = 1. Bits above 4 are always 0.
- R10: When `present_i` = 1 and `rsvd_i` = 1, the access faults with bits 0 and 3 set, whatever the permission checks say. A missing page takes precedence over reserved bits.
- R11: Without a fault, `fault_o` = 0 and `err_code_o` = 0. With a fault, all three rights outputs are 0.
- R12: With `OUT_REG` = 1, the outputs reflect the inputs sampled at the previous rising clock edge, and they are all 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| present_i | input | 1 | Final entry of the walk is present |
| rsvd_i | input | 1 | Walker found a reserved bit set |
| pg_user_i | input | 1 | Combined user attribute |
| pg_write_i | input | 1 | Combined writable attribute |
| pg_nx_i | input | 1 | Combined no-execute attribute |
| pg_dirty_i | input | 1 | Final entry already dirty |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 treated as read |
| cpl_i | input | CPL_W | Current privilege level |
| ac_i | input | 1 | Alignment-check flag |
| implicit_i | input | 1 | Implicit supervisor access |
| wp_en_i | input | 1 | Supervisor write-protect enable |
| smap_en_i | input | 1 | Supervisor access prevention enable |
| smep_en_i | input | 1 | Supervisor execution prevention enable |
| nxe_en_i | input | 1 | No-execute feature enable |
| mode_o | output | 2 | Selected mode index: 0 KERNEL-SMAP, 1 USER, 2 KERNEL-NO-SMAP |
| fault_o | output | 1 | Access must raise a page fault |
| err_code_o | output | ERR_W | Page-fault error code |
| rd_ok_o | output | 1 | Cacheable read right |
| wr_ok_o | output | 1 | Cacheable write right |
| ex_ok_o | output | 1 | Cacheable execute right |

## Verification
The bench concentrates on the seams between the three mode indices. These include level 3 with alignment check on an implicit access, where a swapped index rule would open user pages to the kernel, and fetches from user pages under KERNEL-SMAP, where a design that forgot the fetch exemption would fault legitimate code. Errors in error-code composition are targeted directly. A not-present page must not set bit 0, and a reserved-bit fault must win over a simultaneous protection fault. Leaving either wrong would misreport the cause to the handler. Cached rights are probed for the SMEP execute removal and for the dirty-only write grant. Getting either wrong would let a TLB hit bypass a later dirty update or run supervisor code from user pages.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

   typedef enum logic [1:0] {
      MODE_KSMAP   = 2'd0,
      MODE_USER    = 2'd1,
      MODE_KNOSMAP = 2'd2
   } pmode_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   localparam int unsigned ERRB_PROT  = 0;
   localparam int unsigned ERRB_WRITE = 1;
   localparam int unsigned ERRB_USER  = 2;
   localparam int unsigned ERRB_RSVD  = 3;
   localparam int unsigned ERRB_FETCH = 4;
   localparam int unsigned ERR_MIN_W  = 5;

   typedef struct packed {
      logic usr;
      logic wr;
      logic nx;
      logic dirty;
   } pgattr_t;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

endpackage

// File: rtl/page_perm_mode_sel.sv
module page_perm_mode_sel
   import page_perm_pkg::*;
#(
   parameter int unsigned CPL_W = 2
) (
   input  logic [CPL_W-1:0] cpl_i,
   input  logic             ac_i,
   input  logic             implicit_i,
   input  logic             smap_en_i,
   output pmode_e           mode_o
);
   localparam logic [CPL_W-1:0] USER_CPL = {CPL_W{1'b1}};

   logic at_user;
   logic ac_lifts;

   always_comb begin
      at_user  = (cpl_i == USER_CPL);
      ac_lifts = ac_i && !at_user;
      if (!implicit_i && at_user) begin
         mode_o = MODE_USER;
      end else if (!smap_en_i || ac_lifts) begin
         mode_o = MODE_KNOSMAP;
      end else begin
         mode_o = MODE_KSMAP;
      end
   end
endmodule

// File: rtl/page_perm_rules.sv
module page_perm_rules
   import page_perm_pkg::*;
(
   input  pmode_e  mode_i,
   input  acc_e    acc_i,
   input  pgattr_t attr_i,
   input  logic    smep_en_i,
   input  logic    wp_en_i,
   output logic    prot_fault_o
);
   logic is_fetch, is_wr;
   logic f_nx, f_user, f_smap, f_base, f_mode;

   always_comb begin
      is_fetch = (acc_i == ACC_FETCH);
      is_wr    = (acc_i == ACC_WRITE);
      f_nx     = is_fetch && attr_i.nx;
      f_user   = !attr_i.usr || (is_wr && !attr_i.wr);
      f_smap   = !is_fetch && attr_i.usr;
      f_base   = (is_fetch && smep_en_i && attr_i.usr) ||
                 (wp_en_i && is_wr && !attr_i.wr);
      unique case (mode_i)
         MODE_USER:  f_mode = f_user;
         MODE_KSMAP: f_mode = f_smap || f_base;
         default:    f_mode = f_base;
      endcase
      prot_fault_o = f_nx || f_mode;
   end
endmodule

// File: rtl/page_perm_errgen.sv
module page_perm_errgen
   import page_perm_pkg::*;
#(
   parameter int unsigned ERR_W = 5
) (
   input  logic             present_i,
   input  logic             rsvd_i,
   input  logic             prot_fault_i,
   input  acc_e             acc_i,
   input  pmode_e           mode_i,
   input  logic             nxe_en_i,
   output logic             fault_o,
   output logic [ERR_W-1:0] err_o
);
   always_comb begin
      fault_o = !present_i || rsvd_i || prot_fault_i;
      err_o   = '0;
      if (fault_o) begin
         err_o[ERRB_WRITE] = (acc_i == ACC_WRITE);
         err_o[ERRB_USER]  = (mode_i == MODE_USER);
         err_o[ERRB_FETCH] = (acc_i == ACC_FETCH) && nxe_en_i;
         if (present_i) begin
            err_o[ERRB_PROT] = 1'b1;
            err_o[ERRB_RSVD] = rsvd_i;
         end
      end
   end
endmodule

// File: rtl/page_perm_rights.sv
module page_perm_rights
   import page_perm_pkg::*;
(
   input  logic    fault_i,
   input  pmode_e  mode_i,
   input  pgattr_t attr_i,
   input  logic    smep_en_i,
   input  logic    wp_en_i,
   output rights_t rights_o
);
   always_comb begin
      rights_o = '0;
      if (!fault_i) begin
         rights_o.rd = 1'b1;
         rights_o.ex = !attr_i.nx && !(smep_en_i && attr_i.usr);
         rights_o.wr = attr_i.dirty &&
                       (attr_i.wr || (mode_i != MODE_USER && !wp_en_i));
      end
   end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
   import page_perm_pkg::*;
#(
   parameter int unsigned CPL_W   = 2,
   parameter int unsigned ERR_W   = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             present_i,
   input  logic             rsvd_i,
   input  logic             pg_user_i,
   input  logic             pg_write_i,
   input  logic             pg_nx_i,
   input  logic             pg_dirty_i,
   input  logic [1:0]       acc_i,
   input  logic [CPL_W-1:0] cpl_i,
   input  logic             ac_i,
   input  logic             implicit_i,
   input  logic             wp_en_i,
   input  logic             smap_en_i,
   input  logic             smep_en_i,
   input  logic             nxe_en_i,
   output logic [1:0]       mode_o,
   output logic             fault_o,
   output logic [ERR_W-1:0] err_code_o,
   output logic             rd_ok_o,
   output logic             wr_ok_o,
   output logic             ex_ok_o
);
   if (ERR_W < ERR_MIN_W) begin : g_bad_err_w
      $error("page_perm_check: ERR_W must be at least %0d", ERR_MIN_W);
   end
   if (CPL_W < 1) begin : g_bad_cpl_w
      $error("page_perm_check: CPL_W must be at least 1");
   end

   acc_e             acc;
   pgattr_t          attr;
   pmode_e           mode;
   logic             prot_fault;
   logic             fault;
   logic [ERR_W-1:0] err;
   rights_t          rights;

   assign acc  = acc_e'(acc_i);
   assign attr = '{usr: pg_user_i, wr: pg_write_i, nx: pg_nx_i, dirty: pg_dirty_i};

   page_perm_mode_sel #(.CPL_W(CPL_W)) mode_sel_i (
      .cpl_i      (cpl_i),
      .ac_i       (ac_i),
      .implicit_i (implicit_i),
      .smap_en_i  (smap_en_i),
      .mode_o     (mode)
   );

   page_perm_rules rules_i (
      .mode_i       (mode),
      .acc_i        (acc),
      .attr_i       (attr),
      .smep_en_i    (smep_en_i),
      .wp_en_i      (wp_en_i),
      .prot_fault_o (prot_fault)
   );

   page_perm_errgen #(.ERR_W(ERR_W)) errgen_i (
      .present_i    (present_i),
      .rsvd_i       (rsvd_i),
      .prot_fault_i (prot_fault),
      .acc_i        (acc),
      .mode_i       (mode),
      .nxe_en_i     (nxe_en_i),
      .fault_o      (fault),
      .err_o        (err)
   );

   page_perm_rights rights_i (
      .fault_i   (fault),
      .mode_i    (mode),
      .attr_i    (attr),
      .smep_en_i (smep_en_i),
      .wp_en_i   (wp_en_i),
      .rights_o  (rights)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mode_o     <= '0;
            fault_o    <= 1'b0;
            err_code_o <= '0;
            rd_ok_o    <= 1'b0;
            wr_ok_o    <= 1'b0;
            ex_ok_o    <= 1'b0;
         end else begin
            mode_o     <= mode;
            fault_o    <= fault;
            err_code_o <= err;
            rd_ok_o    <= rights.rd;
            wr_ok_o    <= rights.wr;
            ex_ok_o    <= rights.ex;
         end
      end
   end else begin : g_out_comb
      assign mode_o     = mode;
      assign fault_o    = fault;
      assign err_code_o = err;
      assign rd_ok_o    = rights.rd;
      assign wr_ok_o    = rights.wr;
      assign ex_ok_o    = rights.ex;
   end
endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva #(
   parameter int unsigned CPL_W   = 2,
   parameter int unsigned ERR_W   = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             present_i,
   input logic             rsvd_i,
   input logic             pg_user_i,
   input logic             pg_nx_i,
   input logic [1:0]       acc_i,
   input logic [CPL_W-1:0] cpl_i,
   input logic             implicit_i,
   input logic             smep_en_i,
   input logic [1:0]       mode_o,
   input logic             fault_o,
   input logic [ERR_W-1:0] err_code_o,
   input logic             rd_ok_o,
   input logic             wr_ok_o,
   input logic             ex_ok_o
);
   logic             s_present, s_rsvd, s_user, s_nx, s_impl, s_smep, v_ok;
   logic [1:0]       s_acc;
   logic [CPL_W-1:0] s_cpl;

   if (OUT_REG) begin : g_delay
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_ok <= 1'b0;
            s_present <= 1'b0; s_rsvd <= 1'b0; s_user <= 1'b0; s_nx <= 1'b0;
            s_impl <= 1'b0; s_smep <= 1'b0; s_acc <= '0; s_cpl <= '0;
         end else begin
            v_ok <= 1'b1;
            s_present <= present_i; s_rsvd <= rsvd_i; s_user <= pg_user_i;
            s_nx <= pg_nx_i; s_impl <= implicit_i; s_smep <= smep_en_i;
            s_acc <= acc_i; s_cpl <= cpl_i;
         end
      end
   end else begin : g_same
      assign v_ok = 1'b1;
      assign s_present = present_i; assign s_rsvd = rsvd_i; assign s_user = pg_user_i;
      assign s_nx = pg_nx_i; assign s_impl = implicit_i; assign s_smep = smep_en_i;
      assign s_acc = acc_i; assign s_cpl = cpl_i;
   end

   p_user_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && !s_impl && (s_cpl == {CPL_W{1'b1}}) |-> mode_o == 2'd1);

   p_implicit_kernel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && s_impl |-> mode_o != 2'd1);

   p_nx_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && s_present && !s_rsvd && s_acc == 2'd2 && s_nx
      |-> fault_o && err_code_o[0] && !err_code_o[3]);

   p_not_present_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && !s_present |-> fault_o && !err_code_o[0] && !err_code_o[3]);

   p_rsvd_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && s_present && s_rsvd |-> fault_o && err_code_o[0] && err_code_o[3]);

   p_clean_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && !fault_o |-> err_code_o == '0 && rd_ok_o);

   p_no_rights_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && fault_o |-> !rd_ok_o && !wr_ok_o && !ex_ok_o);

   p_smep_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_ok && !fault_o && s_smep && s_user |-> !ex_ok_o);
endmodule

bind page_perm_check page_perm_check_sva #(
   .CPL_W(CPL_W), .ERR_W(ERR_W), .OUT_REG(OUT_REG)
) sva_i (.*);

// File: tb/page_perm_check_tb_top.sv
module page_perm_check_tb_top;
   localparam int ERR_W = 5;

   typedef struct {
      logic present, rsvd, u, w, nx, dirty;
      logic [1:0] acc, cpl;
      logic ac, impl, wp, smap, smep, nxe;
   } stim_t;

   typedef struct {
      logic [1:0]       mode;
      logic             fault;
      logic [ERR_W-1:0] err;
      logic [2:0]       rwx;
      string            tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic present, rsvd, u, w, nx, dirty, ac, impl, wp, smap, smep, nxe;
   logic [1:0] acc, cpl;
   logic [1:0] mode_o;
   logic fault_o, rd_o, wr_o, ex_o;
   logic [ERR_W-1:0] err_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;

   page_perm_check #(.CPL_W(2), .ERR_W(ERR_W), .OUT_REG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .present_i(present), .rsvd_i(rsvd),
      .pg_user_i(u), .pg_write_i(w), .pg_nx_i(nx), .pg_dirty_i(dirty),
      .acc_i(acc), .cpl_i(cpl), .ac_i(ac), .implicit_i(impl), .wp_en_i(wp),
      .smap_en_i(smap), .smep_en_i(smep), .nxe_en_i(nxe),
      .mode_o(mode_o), .fault_o(fault_o), .err_code_o(err_o),
      .rd_ok_o(rd_o), .wr_ok_o(wr_o), .ex_ok_o(ex_o)
   );

   function automatic stim_t base();
      stim_t s;
      s.present = 1; s.rsvd = 0; s.u = 0; s.w = 1; s.nx = 0; s.dirty = 0;
      s.acc = 2'd0; s.cpl = 2'd0; s.ac = 0; s.impl = 0; s.wp = 0;
      s.smap = 1; s.smep = 0; s.nxe = 1;
      return s;
   endfunction

   // Reference model written from the requirements
   function automatic exp_t model(stim_t s, string tag);
      exp_t e;
      logic f, wr_acc, fe, prot;
      wr_acc = (s.acc == 2'd1);
      fe     = (s.acc == 2'd2);
      if (s.cpl == 2'd3 && !s.impl)                e.mode = 2'd1;   // R1
      else if (!s.smap)                            e.mode = 2'd2;
      else if (s.ac && s.cpl != 2'd3)              e.mode = 2'd2;   // R1, R2
      else                                         e.mode = 2'd0;
      prot = 0;
      if (fe && s.nx) prot = 1;                                       // R3
      if (e.mode == 2'd1) begin
         if (!s.u) prot = 1;                                          // R4
         if (wr_acc && !s.w) prot = 1;
      end else begin
         if (e.mode == 2'd0 && !fe && s.u) prot = 1;                  // R5
         if (fe && s.smep && s.u) prot = 1;                           // R6
         if (s.wp && wr_acc && !s.w) prot = 1;
      end
      f = !s.present || s.rsvd || prot;
      e.fault = f;
      e.err = '0;
      e.rwx = 3'b000;
      if (f) begin
         e.err[1] = wr_acc;
         e.err[2] = (e.mode == 2'd1);
         e.err[4] = fe && s.nxe;
         if (s.present) begin
            e.err[0] = 1;
            e.err[3] = s.rsvd;
         end
      end else begin
         e.rwx[2] = 1;
         e.rwx[1] = s.dirty && (s.w || (e.mode != 2'd1 && !s.wp));
         e.rwx[0] = !s.nx && !(s.smep && s.u);
      end
      e.tag = tag;
      return e;
   endfunction

   task automatic send(stim_t s, string tag);
      @(negedge clk);
      present = s.present; rsvd = s.rsvd; u = s.u; w = s.w; nx = s.nx;
      dirty = s.dirty; acc = s.acc; cpl = s.cpl; ac = s.ac; impl = s.impl;
      wp = s.wp; smap = s.smap; smep = s.smep; nxe = s.nxe;
      q.push_back(model(s, tag));
   endtask

   // Monitor: one result per cycle, one cycle after the driver
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (mode_o !== e.mode || fault_o !== e.fault || err_o !== e.err ||
                {rd_o, wr_o, ex_o} !== e.rwx) begin
               n_fail++;
               $display("FAIL %s: mode=%0d fault=%b err=%b rwx=%b expected mode=%0d fault=%b err=%b rwx=%b",
                        e.tag, mode_o, fault_o, err_o, {rd_o, wr_o, ex_o},
                        e.mode, e.fault, e.err, e.rwx);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog R12: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      stim_t s;
      s = base();
      present = 1; rsvd = 1; u = 1; w = 0; nx = 1; dirty = 1; acc = 2'd1;
      cpl = 2'd3; ac = 1; impl = 0; wp = 1; smap = 1; smep = 1; nxe = 1;
      repeat (3) @(posedge clk);
      #2;
      n_tests++;   // R12 reset state
      if ({mode_o, fault_o, err_o, rd_o, wr_o, ex_o} !== '0) begin
         n_fail++;
         $display("FAIL R12 reset: outputs=%b expected all zero",
                  {mode_o, fault_o, err_o, rd_o, wr_o, ex_o});
      end
      @(negedge clk);
      rst_n = 1'b1;

      s = base(); s.cpl = 3; s.u = 1;                 send(s, "R1 user level");
      s = base();                                     send(s, "R1 kernel smap");
      s = base(); s.ac = 1;                           send(s, "R1 ac lifts smap");
      s = base(); s.smap = 0;                         send(s, "R1 smap off");
      s = base(); s.impl = 1; s.cpl = 3; s.ac = 1;    send(s, "R2 implicit level3 ac");
      s = base(); s.impl = 1; s.ac = 1;               send(s, "R2 implicit level0 ac");
      s = base(); s.impl = 1; s.cpl = 3; s.smap = 0;  send(s, "R2 implicit smap off");
      s = base(); s.acc = 2; s.nx = 1;                send(s, "R3 kernel nx fetch");
      s = base(); s.cpl = 3; s.u = 1; s.acc = 2; s.nx = 1; send(s, "R3 user nx fetch");
      s = base(); s.cpl = 3;                          send(s, "R4 user to supervisor page");
      s = base(); s.cpl = 3; s.u = 1; s.w = 0; s.acc = 1; send(s, "R4 user write read-only");
      s = base(); s.cpl = 3; s.u = 1; s.acc = 1; s.dirty = 1; send(s, "R4 user write ok");
      s = base(); s.u = 1;                            send(s, "R5 smap read user page");
      s = base(); s.u = 1; s.acc = 2;                 send(s, "R5 smap fetch exempt");
      s = base(); s.w = 0; s.wp = 1; s.acc = 1;       send(s, "R5 smap plus wp rule");
      s = base(); s.smap = 0; s.u = 1; s.smep = 1; s.acc = 2; send(s, "R6 smep fetch");
      s = base(); s.smap = 0; s.w = 0; s.acc = 1; s.dirty = 1; send(s, "R6 wp off write");
      s = base(); s.smap = 0; s.w = 0; s.acc = 1; s.wp = 1; send(s, "R6 wp on write");
      s = base(); s.smap = 0; s.u = 1; s.smep = 1;    send(s, "R7 smep drops exec");
      s = base(); s.dirty = 0;                        send(s, "R7 clean no write");
      s = base(); s.dirty = 1;                        send(s, "R7 dirty write");
      s = base(); s.cpl = 3; s.u = 1; s.w = 0; s.dirty = 1; send(s, "R7 user read-only dirty");
      s = base(); s.present = 0; s.cpl = 3; s.acc = 1; send(s, "R8 not present");
      s = base(); s.rsvd = 1;                         send(s, "R8 reserved bits");
      s = base(); s.present = 0; s.acc = 2; s.nxe = 0; send(s, "R9 fetch nxe off");
      s = base(); s.present = 0; s.acc = 2;           send(s, "R9 fetch nxe on");
      s = base(); s.rsvd = 1; s.cpl = 3; s.acc = 1; s.w = 0; send(s, "R10 rsvd over prot");
      s = base(); s.present = 0; s.rsvd = 1;          send(s, "R10 missing over rsvd");
      s = base(); s.nx = 0; s.dirty = 1; s.smap = 0;  send(s, "R11 clean pass");

      repeat (3) @(posedge clk);
      #3;
      if (q.size() != 0) begin
         n_tests++;
         n_fail++;
         $display("FAIL R12: %0d results missing, expected 0", q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule